// File: doc/BRIEF.md
# Packed Saturating Add/Subtract Unit

This unit adds or subtracts two operands lane by lane and clamps each lane to its representable range instead of letting it wrap. A 3-bit format selector picks the lane width and the signedness. Lanes of a quarter, half or the whole of a 32-bit word work on the low word of each operand. A fourth width treats each operand as one 64-bit value. Lanes are computed independently. A lane that stays in range returns its exact wrapped result, and a lane that leaves its range returns the nearest bound.

The result is registered and comes with a valid output one cycle after the input strobe. A sticky saturation flag records that at least one lane has clamped since it was last cleared. It is kept apart from any ordinary overflow indication, and the surrounding logic clears it with a single-cycle pulse.

Top module: `psat_unit`

## Requirements
- R1: Unsigned add (fmt[0]=1, op_sub=0): when the true sum of a lane exceeds the lane's maximum, the lane result is all ones. Otherwise it is the exact sum.
- R2: Unsigned subtract (fmt[0]=1, op_sub=1): when the lane of op_a is smaller than the lane of op_b, the lane result is zero. Otherwise it is the exact difference.
- R3: Signed add (fmt[0]=0, op_sub=0) saturates a lane only when both lane operands share a sign and the wrapped sum has the other sign. Operands of opposite signs never saturate.
- R4: Signed subtract (fmt[0]=0, op_sub=1) saturates a lane only when the lane operands differ in sign and the wrapped difference has a sign different from the op_a lane.
- R5: A signed lane that saturates returns the most negative value when its op_a lane is negative, and the most positive value otherwise.
- R6: fmt[2:1] selects the lane width: 0 gives 8-bit lanes, 1 gives 16-bit lanes and 2 gives one 32-bit lane, all on bits 31:0. 3 gives one 64-bit lane. In the narrow widths, bits 63:32 of both operands are ignored and result[63:32] is zero.
- R7: Each lane saturates independently, so a lane that does not overflow returns its wrapped result even when its neighbours clamp.
- R8: sat_flag is set at the edge that registers a result in which any lane saturated.
- R9: sat_flag stays set until sat_clear is high at a clock edge. If a saturating operation is accepted at that same edge, the flag stays set.
- R10: result and res_valid update at the clock edge that samples in_valid high. res_valid is high for exactly that one cycle. While in_valid is low, result holds its last value.
- R11: While rst_n is low, res_valid, sat_flag and result are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operands and controls are valid this cycle |
| op_sub | input | 1 | 1 = subtract op_b from op_a, 0 = add |
| fmt | input | 3 | [2:1] lane width code, [0] 1 = unsigned |
| op_a | input | 64 | First operand |
| op_b | input | 64 | Second operand |
| sat_clear | input | 1 | Clears the sticky saturation flag |
| res_valid | output | 1 | result was registered at the last edge |
| result | output | 64 | Registered saturated result |
| sat_flag | output | 1 | Sticky cumulative saturation flag |

## Verification
Every output is due exactly one edge after the inputs that cause it. result, res_valid and sat_flag all come from the edge that samples the strobe, and a clear takes effect at the edge that samples it. The bench drives each input set at a falling edge and updates its behavioural model of the next state at the same moment. It then compares all three outputs 1 ns after the following rising edge, so each expected value is checked in the cycle it becomes due. The model finds saturation by computing each lane exactly in a wider signed range and clamping, rather than by inspecting sign bits.

// File: rtl/psat_pkg.sv
package psat_pkg;

   typedef enum logic [1:0] {
      LSZ_QUARTER = 2'd0,
      LSZ_HALF    = 2'd1,
      LSZ_WORD    = 2'd2,
      LSZ_DOUBLE  = 2'd3
   } lane_sz_e;

   typedef struct packed {
      logic sub;
      logic uns;
   } arith_ctl_t;

endpackage

// File: rtl/psat_lane.sv
module psat_lane
   import psat_pkg::*;
#(
   parameter int W = 8
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   input  arith_ctl_t   ctl,
   output logic [W-1:0] y,
   output logic         sat
);

   initial assert (W >= 2) else $error("psat_lane: W must be at least 2");

   logic [W:0]   ext;
   logic [W-1:0] wrap;
   logic         sign_flip;
   logic         sign_diff;
   logic         ovf;
   logic [W-1:0] bound;

   always_comb begin
      ext       = ctl.sub ? ({1'b0, a} - {1'b0, b}) : ({1'b0, a} + {1'b0, b});
      wrap      = ext[W-1:0];
      sign_flip = wrap[W-1] ^ a[W-1];
      sign_diff = a[W-1] ^ b[W-1];
      if (ctl.uns) begin
         ovf   = ext[W];
         bound = ctl.sub ? '0 : '1;
      end else begin
         ovf   = sign_flip & (ctl.sub ? sign_diff : ~sign_diff);
         bound = a[W-1] ? {1'b1, {(W-1){1'b0}}} : {1'b0, {(W-1){1'b1}}};
      end
      y   = ovf ? bound : wrap;
      sat = ovf;
   end

   // R5: a signed clamp keeps the sign of the first operand
   always_comb begin
      if (sat && !ctl.uns) begin
         a_r5_signed_clamp_sign: assert (y[W-1] == a[W-1])
            else $error("R5 clamp sign mismatch");
      end
   end

endmodule

// File: rtl/psat_lane_row.sv
module psat_lane_row
   import psat_pkg::*;
#(
   parameter int ROW_W  = 32,
   parameter int LANE_W = 8
) (
   input  logic [ROW_W-1:0] a,
   input  logic [ROW_W-1:0] b,
   input  arith_ctl_t       ctl,
   output logic [ROW_W-1:0] y,
   output logic             any_sat
);

   localparam int N_LANES = ROW_W / LANE_W;

   initial assert (ROW_W % LANE_W == 0 && N_LANES >= 1)
      else $error("psat_lane_row: ROW_W must be a multiple of LANE_W");

   logic [N_LANES-1:0] lane_sat;

   for (genvar i = 0; i < N_LANES; i++) begin : g_lane
      psat_lane #(.W(LANE_W)) u_lane (
         .a   (a[i*LANE_W +: LANE_W]),
         .b   (b[i*LANE_W +: LANE_W]),
         .ctl (ctl),
         .y   (y[i*LANE_W +: LANE_W]),
         .sat (lane_sat[i])
      );
   end

   assign any_sat = |lane_sat;

endmodule

// File: rtl/psat_unit.sv
module psat_unit
   import psat_pkg::*;
#(
   parameter int NARROW_W = 32
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  in_valid,
   input  logic                  op_sub,
   input  logic [2:0]            fmt,
   input  logic [2*NARROW_W-1:0] op_a,
   input  logic [2*NARROW_W-1:0] op_b,
   input  logic                  sat_clear,
   output logic                  res_valid,
   output logic [2*NARROW_W-1:0] result,
   output logic                  sat_flag
);

   localparam int WIDE_W     = 2 * NARROW_W;
   localparam int MIN_LANE_W = NARROW_W / 4;
   localparam int N_SZ       = 4;

   initial assert (NARROW_W % 4 == 0 && NARROW_W >= 8)
      else $error("psat_unit: NARROW_W must be a multiple of 4, at least 8");

   arith_ctl_t        ctl;
   lane_sz_e          sz_sel;
   logic [WIDE_W-1:0] row_y [N_SZ];
   logic [N_SZ-1:0]   row_sat;
   logic [WIDE_W-1:0] sel_y;
   logic              sel_sat;

   assign ctl    = '{sub: op_sub, uns: fmt[0]};
   assign sz_sel = lane_sz_e'(fmt[2:1]);

   for (genvar k = 0; k < N_SZ; k++) begin : g_sz
      if (k == N_SZ - 1) begin : g_wide
         psat_lane_row #(.ROW_W(WIDE_W), .LANE_W(WIDE_W)) u_row (
            .a       (op_a),
            .b       (op_b),
            .ctl     (ctl),
            .y       (row_y[k]),
            .any_sat (row_sat[k])
         );
      end else begin : g_narrow
         logic [NARROW_W-1:0] y_n;
         psat_lane_row #(.ROW_W(NARROW_W), .LANE_W(MIN_LANE_W << k)) u_row (
            .a       (op_a[NARROW_W-1:0]),
            .b       (op_b[NARROW_W-1:0]),
            .ctl     (ctl),
            .y       (y_n),
            .any_sat (row_sat[k])
         );
         assign row_y[k] = {{NARROW_W{1'b0}}, y_n};
      end
   end

   assign sel_y   = row_y[sz_sel];
   assign sel_sat = row_sat[sz_sel];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         res_valid <= 1'b0;
         result    <= '0;
         sat_flag  <= 1'b0;
      end else begin
         res_valid <= in_valid;
         if (in_valid) result <= sel_y;
         sat_flag <= (sat_flag & ~sat_clear) | (in_valid & sel_sat);
      end
   end

   // R10: a strobe gives exactly one valid cycle
   a_r10_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> res_valid);
   a_r10_valid_drops: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !res_valid);
   // R10: result holds while idle
   a_r10_result_holds: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> $stable(result));
   // R6: narrow widths leave the upper half zero
   a_r6_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && fmt[2:1] != 2'b11) |=> result[WIDE_W-1:NARROW_W] == '0);
   // R8: any saturating lane sets the flag
   a_r8_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && sel_sat) |=> sat_flag);
   // R9: the flag is sticky without a clear
   a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (sat_flag && !sat_clear) |=> sat_flag);
   // R9: a clear without a new saturation empties the flag
   a_r9_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (sat_clear && !(in_valid && sel_sat)) |=> !sat_flag);

endmodule

// File: tb/test_psat_unit.sv
`timescale 1ns/1ps
module test_psat_unit;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        in_valid;
   logic        op_sub;
   logic [2:0]  fmt;
   logic [63:0] op_a;
   logic [63:0] op_b;
   logic        sat_clear;
   logic        res_valid;
   logic [63:0] result;
   logic        sat_flag;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   logic        e_valid = 1'b0;
   logic [63:0] e_res   = '0;
   logic        e_flag  = 1'b0;

   always #2.5 clk = ~clk;

   psat_unit i_psat_unit (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (in_valid),
      .op_sub    (op_sub),
      .fmt       (fmt),
      .op_a      (op_a),
      .op_b      (op_b),
      .sat_clear (sat_clear),
      .res_valid (res_valid),
      .result    (result),
      .sat_flag  (sat_flag)
   );

   // Exact lane arithmetic in a wide signed range, then clamp
   function automatic void model(input logic [63:0] a, input logic [63:0] b,
                                 input logic sub, input logic [2:0] f,
                                 output logic [63:0] r, output logic s);
      int w;
      int n;
      logic [63:0] mask;
      w    = (f[2:1] == 2'd3) ? 64 : (8 << f[2:1]);
      n    = (f[2:1] == 2'd3) ? 1 : 32 / w;
      mask = (w == 64) ? '1 : ((64'd1 << w) - 64'd1);
      r = '0;
      s = 1'b0;
      for (int i = 0; i < n; i++) begin
         logic [63:0] la;
         logic [63:0] lb;
         logic signed [67:0] ea;
         logic signed [67:0] eb;
         logic signed [67:0] ex;
         logic signed [67:0] lo;
         logic signed [67:0] hi;
         la = (a >> (i * w)) & mask;
         lb = (b >> (i * w)) & mask;
         ea = $signed({4'b0, la});
         eb = $signed({4'b0, lb});
         if (!f[0] && la[w-1]) ea = ea - (68'sd1 <<< w);
         if (!f[0] && lb[w-1]) eb = eb - (68'sd1 <<< w);
         ex = sub ? (ea - eb) : (ea + eb);
         if (f[0]) begin
            lo = 68'sd0;
            hi = $signed({4'b0, mask});
         end else begin
            lo = -(68'sd1 <<< (w - 1));
            hi = (68'sd1 <<< (w - 1)) - 68'sd1;
         end
         if (ex > hi) begin
            ex = hi;
            s  = 1'b1;
         end else if (ex < lo) begin
            ex = lo;
            s  = 1'b1;
         end
         r = r | ((64'(ex) & mask) << (i * w));
      end
   endfunction

   task automatic check(input string tag, input string what,
                        input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   task automatic step(input logic v, input logic s, input logic [2:0] f,
                       input logic [63:0] a, input logic [63:0] b,
                       input logic clr, input string tag);
      logic [63:0] m_r;
      logic        m_s;
      @(negedge clk);
      in_valid  = v;
      op_sub    = s;
      fmt       = f;
      op_a      = a;
      op_b      = b;
      sat_clear = clr;
      model(a, b, s, f, m_r, m_s);
      e_flag  = (e_flag & ~clr) | (v & m_s);
      e_valid = v;
      if (v) e_res = m_r;
      @(posedge clk);
      #1;
      check(tag, "res_valid", {63'b0, res_valid}, {63'b0, e_valid});
      check(tag, "result", result, e_res);
      check(tag, "sat_flag", {63'b0, sat_flag}, {63'b0, e_flag});
   endtask

   initial begin
      #(150000 * 5);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0; in_valid = 1'b0; op_sub = 1'b0; fmt = 3'd0;
      op_a = '0; op_b = '0; sat_clear = 1'b0;
      repeat (3) @(posedge clk);
      #1;
      // R11: reset state
      check("R11", "res_valid", {63'b0, res_valid}, 64'd0);
      check("R11", "result", result, 64'd0);
      check("R11", "sat_flag", {63'b0, sat_flag}, 64'd0);
      @(negedge clk);
      rst_n = 1'b1;

      // R1 with mixed lanes (R7): 8-bit unsigned add
      step(1, 0, 3'b001, 64'h0000_0000_FF10_8001, 64'h0000_0000_01F0_8001, 0, "R1");
      step(1, 0, 3'b001, 64'h0000_0000_1020_3040, 64'h0000_0000_0102_0304, 1, "R7");
      // R2: 16-bit unsigned subtract
      step(1, 1, 3'b011, 64'h0000_0000_0005_0010, 64'h0000_0000_0006_0001, 0, "R2");
      step(1, 1, 3'b101, 64'h0000_0000_0000_0007, 64'h0000_0000_0000_0007, 1, "R2");
      // R3/R5: 32-bit signed add, both directions
      step(1, 0, 3'b100, 64'h0000_0000_7FFF_FFFF, 64'h0000_0000_0000_0001, 1, "R3");
      step(1, 0, 3'b100, 64'h0000_0000_8000_0000, 64'h0000_0000_FFFF_FFFF, 1, "R5");
      step(1, 0, 3'b000, 64'h0000_0000_7F80_7F80, 64'h0000_0000_807F_7F80, 1, "R3");
      // R4/R5: 8-bit signed subtract
      step(1, 1, 3'b000, 64'h0000_0000_807F_05F0, 64'h0000_0000_01FF_037F, 1, "R4");
      step(1, 1, 3'b010, 64'h0000_0000_8000_7FFF, 64'h0000_0000_8000_7FFF, 1, "R4");
      // R6: 64-bit lanes in all four modes, then ignored upper bits
      step(1, 0, 3'b111, 64'hFFFF_FFFF_FFFF_FFF0, 64'h0000_0000_0000_0020, 1, "R6");
      step(1, 1, 3'b111, 64'h0000_0000_0000_0001, 64'h0000_0000_0000_0002, 1, "R6");
      step(1, 0, 3'b110, 64'h7FFF_FFFF_FFFF_FFFF, 64'h0000_0000_0000_0005, 1, "R6");
      step(1, 1, 3'b110, 64'h8000_0000_0000_0000, 64'h0000_0000_0000_0001, 1, "R6");
      step(1, 0, 3'b101, 64'hDEAD_BEEF_0000_0001, 64'hCAFE_F00D_0000_0002, 1, "R6");
      // R9: sticky, clear, and set winning over clear
      step(1, 0, 3'b001, 64'h0000_0000_0000_00FF, 64'h0000_0000_0000_0001, 0, "R8");
      step(0, 0, 3'b001, 64'h0, 64'h0, 0, "R9");
      step(0, 0, 3'b001, 64'h0, 64'h0, 0, "R9");
      step(0, 0, 3'b001, 64'h0, 64'h0, 1, "R9");
      step(1, 0, 3'b001, 64'h0000_0000_0000_00FF, 64'h0000_0000_0000_0001, 1, "R9");
      step(1, 0, 3'b001, 64'h0000_0000_0000_0001, 64'h0000_0000_0000_0001, 1, "R9");
      // R10: idle cycles with changing operands keep the result
      step(1, 0, 3'b001, 64'h0000_0000_0102_0304, 64'h0000_0000_0101_0101, 0, "R10");
      step(0, 1, 3'b111, 64'hFFFF_0000_FFFF_0000, 64'h1234_5678_9ABC_DEF0, 0, "R10");
      step(0, 0, 3'b000, 64'h0000_0000_7F7F_7F7F, 64'h0000_0000_7F7F_7F7F, 0, "R10");
      // R7: random mixes over all modes
      for (int i = 0; i < 400; i++) begin
         step(($urandom % 4) != 0, $urandom % 2, 3'($urandom % 8),
              {$urandom, $urandom}, {$urandom, $urandom}, ($urandom % 5) == 0, "R7");
      end
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule